// File: doc/BRIEF.md
# ADC Power-Down Sequencer Master

This block is a host-side serial master for a dual-channel 12-bit successive-approximation converter that has no control register for power. It drives the chip select (active low) and the serial clock, and it collects both data lines at once. Power state changes are expressed only through the length of each chip-select frame. A full frame of 16 serial clocks is a conversion. A frame cut short after the fifth falling clock edge sends the converter one step deeper into power-down. A full-length dummy frame sent to a sleeping converter wakes it.

The host gives a 2-bit command and a one-cycle start strobe. The master keeps its own copy of the converter's power state. It decides whether the command is legal in that state and how many frames it takes. After a wake from the deepest state it holds `busy` for a configurable number of cycles, counted from the chip-select falling edge of the dummy frame. Conversions are therefore not started before the converter has powered up. The serial clock rate and that wake delay are parameters.

Top module: `adc_pwr_seq`

## Requirements
- R1: Out of reset and whenever idle, `cs_n` is 1, `sclk` is 1, `busy` is 0 and `res_valid` is 0. `sclk` falls only while `cs_n` is 0.
- R2: Command codes are 0 convert, 1 nap, 2 sleep and 3 wake. A start strobe is taken when `busy` is 0 and the command is legal for the tracked power state. `busy` is then 1 from the next cycle until the command finishes. This includes a start given in the very cycle in which `busy` has just fallen.
- R3: A convert frame has exactly 16 `sclk` falling edges. Each data line is sampled at the rising `sclk` edge that follows each falling edge, MSB first. `res_a` and `res_b` hold the last 12 bits sampled. `res_valid` is high for one cycle, in the same cycle that `cs_n` returns to 1.
- R4: A nap from the running state sends one frame in which `cs_n` rises after the 5th `sclk` falling edge and before the 6th. No result is reported. The state becomes light sleep.
- R5: A sleep command sends two such short frames from the running state, or one from light sleep. The state becomes deep sleep.
- R6: A wake from deep sleep sends a 16-edge dummy frame and reports no result. `busy` then stays 1 for exactly WAKE_CYC cycles, measured from the first cycle with `cs_n` low.
- R7: A wake from light sleep sends a 16-edge dummy frame and reports no result. `busy` falls (2*16+1)*DIV cycles after `cs_n` falls, and the next convert returns valid data.
- R8: An illegal command has no effect: no frame is sent, `busy` stays 0 and the tracked state is unchanged. Illegal commands are convert outside the running state, nap outside the running state, sleep in deep sleep, and wake in the running state.
- R9: A start strobe given while `busy` is 1 is ignored.
- R10: Consecutive frames are separated by at least DIV cycles with `cs_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 2 | Command code, read with `start` |
| start | input | 1 | One-cycle command strobe |
| sdata_a | input | 1 | Serial data from channel A |
| sdata_b | input | 1 | Serial data from channel B |
| cs_n | output | 1 | Chip select to the converter, active low |
| sclk | output | 1 | Serial clock, rests high |
| res_a | output | 12 | Last channel A result |
| res_b | output | 12 | Last channel B result |
| res_valid | output | 1 | One-cycle strobe for a new result |
| busy | output | 1 | A command is in progress |

## Verification
The end of one command and the acceptance of the next can fall in the same cycle. The bench provokes this by raising `start` in the first cycle it samples `busy` low after each frame. It then requires `busy` to be high again one cycle later. A second coincidence is the result strobe and the chip-select rising edge, which must appear in the same sample. The scoreboard checks this at every frame end, together with the falling-edge count, which distinguishes cut frames from full frames. The wake delays are judged by exact cycle distances from the dummy frame's chip-select falling edge to the fall of `busy`.

// File: rtl/adc_pwr_pkg.sv
package adc_pwr_pkg;

  typedef enum logic [1:0] {
    CMD_CONVERT = 2'd0,
    CMD_NAP     = 2'd1,
    CMD_SLEEP   = 2'd2,
    CMD_WAKE    = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_LIGHT = 2'd1,
    PM_DEEP  = 2'd2
  } pmode_e;

  typedef struct packed {
    logic       legal;
    logic [1:0] frames;     // number of frames to send
    logic       full_len;   // 16-edge frame instead of a cut frame
    logic       capture;    // report the sampled data
    logic       long_wait;  // hold busy for the deep-sleep wake delay
    pmode_e     next_mode;
  } plan_t;

  // Decide what a command means in a given power state (R2, R4, R5, R6, R7, R8)
  function automatic plan_t plan_cmd(cmd_e c, pmode_e m);
    plan_t p;
    p = '0;
    p.next_mode = m;
    case (c)
      CMD_CONVERT: if (m == PM_RUN) begin
        p.legal = 1'b1; p.frames = 2'd1; p.full_len = 1'b1; p.capture = 1'b1;
      end
      CMD_NAP: if (m == PM_RUN) begin
        p.legal = 1'b1; p.frames = 2'd1; p.next_mode = PM_LIGHT;
      end
      CMD_SLEEP: if (m != PM_DEEP) begin
        p.legal = 1'b1; p.frames = (m == PM_RUN) ? 2'd2 : 2'd1; p.next_mode = PM_DEEP;
      end
      default: if (m != PM_RUN) begin
        p.legal = 1'b1; p.frames = 2'd1; p.full_len = 1'b1;
        p.long_wait = (m == PM_DEEP); p.next_mode = PM_RUN;
      end
    endcase
    return p;
  endfunction

endpackage

// File: rtl/adc_pwr_sclk_gen.sv
module adc_pwr_sclk_gen #(
  parameter int DIV  = 8,
  parameter int FC_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  output logic            sclk,
  output logic            rise_ev,
  output logic            fall_ev,
  output logic [FC_W-1:0] fall_cnt
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q;
  logic          tick;

  assign tick    = run && (div_q == DW'(DIV - 1));
  assign rise_ev = tick && !sclk;
  assign fall_ev = tick && sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      sclk     <= 1'b1;
      fall_cnt <= '0;
    end else if (!run) begin
      div_q    <= '0;
      sclk     <= 1'b1;
      fall_cnt <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick)    sclk     <= !sclk;
      if (fall_ev) fall_cnt <= fall_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_pwr_capture.sv
module adc_pwr_capture #(
  parameter int RES_W = 12,
  parameter int LANES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic                        shift_en,
  input  logic [LANES-1:0]            din,
  output logic [LANES-1:0][RES_W-1:0] nxt
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [RES_W-1:0] sh_q;
    assign nxt[g] = {sh_q[RES_W-2:0], din[g]};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sh_q <= '0;
      else if (clear)    sh_q <= '0;
      else if (shift_en) sh_q <= nxt[g];
    end
  end
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
  import adc_pwr_pkg::*;
#(
  parameter int DIV       = 8,
  parameter int WAKE_CYC  = 1000000,
  parameter int RES_W     = 12,
  parameter int FRAME_LEN = 16,
  parameter int CUT_AT    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd,
  input  logic             start,
  input  logic             sdata_a,
  input  logic             sdata_b,
  output logic             cs_n,
  output logic             sclk,
  output logic [RES_W-1:0] res_a,
  output logic [RES_W-1:0] res_b,
  output logic             res_valid,
  output logic             busy
);
  localparam int FC_W = $clog2(FRAME_LEN + 1);
  localparam int WK_W = $clog2(WAKE_CYC + 1);
  localparam int GW   = (DIV > 1) ? $clog2(DIV) : 1;

  typedef enum logic [1:0] {S_IDLE, S_FRAME, S_GAP, S_WAIT} st_e;

  st_e         st_q;
  pmode_e      mode_q, next_q;
  logic [1:0]  frames_q;
  logic        full_q, cap_q, wait_q;
  logic [GW-1:0]   gap_q;
  logic [WK_W-1:0] wake_q;

  plan_t       plan;
  logic        accept_ev, frame_end_ev, gap_done, wake_done;
  logic        rise_ev, fall_ev;
  logic [FC_W-1:0] fall_cnt;
  logic [1:0][RES_W-1:0] nxt;

  assign plan         = plan_cmd(cmd_e'(cmd), mode_q);
  assign accept_ev    = start && (st_q == S_IDLE) && plan.legal;
  assign frame_end_ev = rise_ev &&
                        (fall_cnt == (full_q ? FC_W'(FRAME_LEN) : FC_W'(CUT_AT)));
  assign gap_done     = (gap_q == GW'(DIV - 1));
  assign wake_done    = (wake_q >= WK_W'(WAKE_CYC - 1));

  assign cs_n = (st_q != S_FRAME);
  assign busy = (st_q != S_IDLE);

  adc_pwr_sclk_gen #(.DIV(DIV), .FC_W(FC_W)) sclk_i (
    .clk(clk), .rst_n(rst_n), .run(st_q == S_FRAME),
    .sclk(sclk), .rise_ev(rise_ev), .fall_ev(fall_ev), .fall_cnt(fall_cnt)
  );

  adc_pwr_capture #(.RES_W(RES_W), .LANES(2)) cap_i (
    .clk(clk), .rst_n(rst_n), .clear(accept_ev),
    .shift_en(rise_ev && (st_q == S_FRAME)),
    .din({sdata_b, sdata_a}), .nxt(nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= S_IDLE;
      mode_q    <= PM_RUN;
      next_q    <= PM_RUN;
      frames_q  <= '0;
      full_q    <= 1'b0;
      cap_q     <= 1'b0;
      wait_q    <= 1'b0;
      gap_q     <= '0;
      wake_q    <= '0;
      res_a     <= '0;
      res_b     <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (st_q != S_IDLE && !wake_done) wake_q <= wake_q + 1'b1;
      case (st_q)
        S_IDLE: if (accept_ev) begin
          st_q     <= S_FRAME;
          frames_q <= plan.frames;
          full_q   <= plan.full_len;
          cap_q    <= plan.capture;
          wait_q   <= plan.long_wait;
          next_q   <= plan.next_mode;
          wake_q   <= '0;
        end
        S_FRAME: if (frame_end_ev) begin
          st_q     <= S_GAP;
          gap_q    <= '0;
          frames_q <= frames_q - 1'b1;
          if (cap_q) begin
            res_a     <= nxt[0];
            res_b     <= nxt[1];
            res_valid <= 1'b1;
          end
        end
        S_GAP: begin
          gap_q <= gap_q + 1'b1;
          if (gap_done) begin
            if (frames_q != 2'd0) st_q <= S_FRAME;
            else if (wait_q)      st_q <= S_WAIT;
            else begin
              st_q   <= S_IDLE;
              mode_q <= next_q;
            end
          end
        end
        default: if (wake_done) begin
          st_q   <= S_IDLE;
          mode_q <= next_q;
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_pwr_seq_chk.sv
module adc_pwr_seq_chk #(
  parameter int FRAME_LEN = 16,
  parameter int CUT_AT    = 5,
  parameter int FC_W      = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input logic            sclk,
  input logic            res_valid,
  input logic [FC_W-1:0] fall_cnt
);
  a_r1_sclk_falls_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> !cs_n);

  a_r1_sclk_rests_high: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);

  a_r3_fall_limit: assert property (@(posedge clk) disable iff (!rst_n)
    fall_cnt <= FC_W'(FRAME_LEN));

  a_r4_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> ($past(fall_cnt) == FC_W'(FRAME_LEN) || $past(fall_cnt) == FC_W'(CUT_AT)));

  a_r3_valid_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $rose(cs_n));
endmodule

bind adc_pwr_seq adc_pwr_seq_chk #(
  .FRAME_LEN(FRAME_LEN), .CUT_AT(CUT_AT), .FC_W(FC_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
  .res_valid(res_valid), .fall_cnt(fall_cnt)
);

// File: tb/adc_pwr_seq_tb.sv
module adc_pwr_seq_tb_top;
  localparam int DIV   = 2;
  localparam int WAKE  = 300;
  localparam int RES_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cmd = 2'd0;
  logic start = 1'b0, sdata_a = 1'b0, sdata_b = 1'b0;
  logic cs_n, sclk, res_valid, busy;
  logic [RES_W-1:0] res_a, res_b;

  always #2 clk = ~clk;

  adc_pwr_seq #(.DIV(DIV), .WAKE_CYC(WAKE)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .start(start),
    .sdata_a(sdata_a), .sdata_b(sdata_b), .cs_n(cs_n), .sclk(sclk),
    .res_a(res_a), .res_b(res_b), .res_valid(res_valid), .busy(busy)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  longint cyc = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] dev_word(input int idx, input int lane);
    return 16'(idx * 16'h3b5 + 16'h0a1c) ^ (lane != 0 ? 16'h5e93 : 16'h0000);
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // converter model: loads a word on CS fall, shifts a bit out after each SCLK fall
  int dev_idx = 0;
  logic [15:0] sh_a, sh_b;
  logic d_cs = 1'b1, d_sclk = 1'b1;
  always @(negedge clk) begin
    if (d_cs && !cs_n) begin
      sh_a <= dev_word(dev_idx, 0);
      sh_b <= dev_word(dev_idx, 1);
      dev_idx <= dev_idx + 1;
    end else if (d_sclk && !sclk && !cs_n) begin
      sdata_a <= sh_a[15];
      sdata_b <= sh_b[15];
      sh_a <= sh_a << 1;
      sh_b <= sh_b << 1;
    end
    d_cs <= cs_n;
    d_sclk <= sclk;
  end

  typedef struct {int falls; bit cap; int idx; string req;} item_t;
  item_t q[$];
  int exp_idx = 0;

  // monitor / scoreboard
  logic m_cs = 1'b1, m_sclk = 1'b1;
  int falls = 0, frames_seen = 0;
  longint last_fall_cyc = 0, last_rise_cyc = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (m_cs && !cs_n) begin
        falls = 0;
        if (frames_seen > 0)
          chk(cyc - last_rise_cyc >= DIV, "R10", "cs high gap", cyc - last_rise_cyc, DIV);
        last_fall_cyc = cyc;
      end
      if (m_sclk && !sclk && !cs_n) falls++;
      if (!m_cs && cs_n) begin
        item_t it;
        frames_seen++;
        last_rise_cyc = cyc;
        if (q.size() == 0) chk(1'b0, "R8", "unexpected frame", falls, 0);
        else begin
          it = q.pop_front();
          chk(falls == it.falls, it.req, "falling edges", falls, it.falls);
          chk(res_valid == it.cap, it.req, "res_valid at cs rise", res_valid, it.cap);
          if (it.cap) begin
            chk(res_a == dev_word(it.idx, 0)[11:0], "R3", "res_a", res_a, dev_word(it.idx, 0)[11:0]);
            chk(res_b == dev_word(it.idx, 1)[11:0], "R3", "res_b", res_b, dev_word(it.idx, 1)[11:0]);
          end
        end
      end else if (res_valid) chk(1'b0, "R3", "res_valid without cs rise", 1, 0);
      if (cs_n && !sclk) chk(1'b0, "R1", "sclk low while idle", 0, 1);
    end
    m_cs = cs_n;
    m_sclk = sclk;
  end

  // driver: called just after a negedge; returns at the first negedge with busy low
  task automatic issue(input logic [1:0] c, input int n_frames, input int nfalls,
                       input bit cap, input string req);
    for (int i = 0; i < n_frames; i++) begin
      item_t it;
      it.falls = nfalls; it.cap = cap; it.idx = exp_idx; it.req = req;
      q.push_back(it);
      exp_idx++;
    end
    cmd = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n_frames > 0) begin
      chk(busy == 1'b1, "R2", "busy one cycle after start", busy, 1);
      while (busy) @(negedge clk);
      chk(q.size() == 0, req, "frames left pending", q.size(), 0);
    end else begin
      int seen;
      seen = frames_seen;
      for (int i = 0; i < 40; i++) begin
        if (busy || !cs_n) chk(1'b0, "R8", "illegal command acted", {busy, cs_n}, 1);
        @(negedge clk);
      end
      chk(frames_seen == seen, "R8", "no frame for illegal command", frames_seen, seen);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R2", "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    longint t;
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sclk == 1 && busy == 0 && res_valid == 0, "R1", "reset state",
        {cs_n, sclk, busy, res_valid}, 4'b1100);
    rst_n = 1'b1;
    @(negedge clk);
    // conversions back to back, start given as soon as busy is low (R2, R3)
    issue(2'd0, 1, 16, 1'b1, "R3");
    issue(2'd0, 1, 16, 1'b1, "R3");
    issue(2'd0, 1, 16, 1'b1, "R3");
    // R9: a nap strobe during a conversion is ignored
    begin
      item_t it;
      it.falls = 16; it.cap = 1'b1; it.idx = exp_idx; it.req = "R9";
      q.push_back(it); exp_idx++;
      cmd = 2'd0; start = 1'b1; @(negedge clk);
      cmd = 2'd1; repeat (6) @(negedge clk);
      start = 1'b0;
      while (busy) @(negedge clk);
    end
    issue(2'd0, 1, 16, 1'b1, "R9");      // still running: convert legal
    issue(2'd3, 0, 0, 1'b0, "R8");       // wake in running state
    issue(2'd1, 1, 5, 1'b0, "R4");       // nap
    issue(2'd0, 0, 0, 1'b0, "R8");       // convert in light sleep
    issue(2'd1, 0, 0, 1'b0, "R8");       // nap in light sleep
    // R7: wake from light sleep
    issue(2'd3, 1, 16, 1'b0, "R7");
    t = cyc - last_fall_cyc;
    chk(t == (2 * 16 + 1) * DIV, "R7", "busy time after light wake", t, (2 * 16 + 1) * DIV);
    issue(2'd0, 1, 16, 1'b1, "R7");
    // R5: sleep from running sends two cut frames
    issue(2'd2, 2, 5, 1'b0, "R5");
    issue(2'd2, 0, 0, 1'b0, "R8");       // sleep in deep sleep
    issue(2'd0, 0, 0, 1'b0, "R8");       // convert in deep sleep
    // R6: wake from deep sleep
    issue(2'd3, 1, 16, 1'b0, "R6");
    t = cyc - last_fall_cyc;
    chk(t == WAKE, "R6", "busy time after deep wake", t, WAKE);
    issue(2'd0, 1, 16, 1'b1, "R6");
    // R5: nap then sleep sends one cut frame
    issue(2'd1, 1, 5, 1'b0, "R4");
    issue(2'd2, 1, 5, 1'b0, "R5");
    issue(2'd3, 1, 16, 1'b0, "R6");
    t = cyc - last_fall_cyc;
    chk(t == WAKE, "R6", "busy time after second deep wake", t, WAKE);
    issue(2'd0, 1, 16, 1'b1, "R3");
    repeat (5) @(negedge clk);
    chk(cs_n == 1 && sclk == 1 && busy == 0, "R1", "idle state at end",
        {cs_n, sclk, busy}, 3'b110);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule